// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a single-way data cache placed between a processor-side word port and a slower memory that moves one word per handshaked beat. The byte address of each processor access is split into a tag, a line index and a word select, above a byte offset. The indexed line's valid bit, stored tag and dirty bit decide whether the access is served at once or whether a miss sequence runs. On a miss, a modified victim is first copied back to memory word by word. The full line is then refilled in ascending word order, the tag is stored and the line is marked valid. The access is then retried and completes as a hit.

A request toward memory is raised in the same cycle as the tag lookup. It is withdrawn through a cancel strobe when the lookup hits or when a modified victim has to go out first. On a clean miss it simply stays up, so any memory latency already spent counts toward the first refill beat. A parameter selects write-through operation instead. In that mode no line ever becomes modified, and every processor write is forwarded as one memory write. The processor waits until memory accepts it. Write misses allocate the line in both modes.

The processor holds its request and address stable until it sees `cpu_ready` high. Requests are word aligned. At least two words per line are assumed.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` and `mem_req` are low while no request is presented, and the first access to any address is a miss.
- R2: An access whose line is valid with a matching tag completes in the cycle it is presented (`cpu_ready` high with no wait cycle). A read returns the cached word.
- R3: A lookup that finds the line invalid, or valid with a different tag, stalls the processor (`cpu_ready` low) until the line has been refilled from memory. It then returns the memory word.
- R4: The word returned is the one chosen by address bits [3:2] within the 16-byte line (default parameters).
- R5: In write-back mode a write hit updates only the cache. No memory write beat is issued, and the line becomes modified.
- R6: When a miss replaces a modified line, all four words of the victim are written to the victim's own block address before any refill beat. Memory then holds the processor's data.
- R7: Replacing an unmodified line issues no memory write beat.
- R8: A write miss refills the line first and then merges the written word. Later reads of that line hit, returning the written word and the memory contents of the other words.
- R9: In write-through mode each processor write produces exactly one memory write beat to its word address. The processor stalls until that beat is accepted, and eviction never writes to memory.
- R10: In the first cycle of a request in idle, `mem_req` is high as a read of the block. `mem_cancel` is high when the lookup hits or the victim is modified, and low on a clean miss.
- R11: With 64 lines the index is address bits [9:4] and the tag is bits [31:10]. Addresses 1024 bytes apart conflict, and addresses within one 16-byte block share a line.
- R12: Memory moves one word per accepted beat, so a refill is exactly four read beats. A request not yet accepted keeps its address, direction and strobe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory beat request |
| mem_cancel | output | 1 | Withdraws the speculative request raised this cycle |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Write beat data |
| mem_ack | input | 1 | Memory accepts the beat this cycle (read data valid) |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
A corrupted tag or valid bit shows up at the port on the very next access to that line. It appears either as a false zero-wait hit that returns stale data, or as a needless stall with refill beats. A lost or spurious dirty bit stays hidden until the line is evicted. It is exposed there by the count and addresses of the write beats, and later by a refill that returns old data. The bench therefore counts memory beats around each directed access. It compares every read against a reference image, and in write-through mode it sweeps the whole memory image at the end.

// File: rtl/cache_pkg.sv
// Shared types for the direct-mapped cache.
package cache_pkg;
    // Miss-sequence states of the controller.
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVICT = 2'd1,
        S_FILL  = 2'd2,
        S_WTHRU = 2'd3
    } cstate_e;
endpackage

// File: rtl/cache_tag_store.sv
// Per-line valid bit, tag and (in write-back mode) dirty bit.
// Assumes a single index drives lookup and update; tags carry no reset.
module cache_tag_store #(
    parameter int LINES      = 64,
    parameter int TAG_W      = 22,
    parameter int WRITE_BACK = 1,
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             commit,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic             set_dirty,
    output logic             line_valid,
    output logic [TAG_W-1:0] line_tag,
    output logic             line_dirty
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] dirty_q;

    // Valid bits: cleared on reset, set when a refill commits.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= '0;
        else if (commit) valid_q[idx] <= 1'b1;
    end

    // Tag array: written when a refill commits.
    always_ff @(posedge clk) begin
        if (commit) tag_q[idx] <= commit_tag;
    end

    generate
        if (WRITE_BACK != 0) begin : g_dirty
            // Dirty bits: set on a write hit, cleared by a refill.
            always_ff @(posedge clk) begin
                if (!rst_n)         dirty_q <= '0;
                else if (commit)    dirty_q[idx] <= 1'b0;
                else if (set_dirty) dirty_q[idx] <= 1'b1;
            end

            a_r5_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
                (set_dirty && !commit) |=> dirty_q[$past(idx)]);
        end else begin : g_clean
            // Write-through: no line is ever modified.
            assign dirty_q = '0;
        end
    endgenerate

    assign line_valid = valid_q[idx];
    assign line_tag   = tag_q[idx];
    assign line_dirty = dirty_q[idx];

    a_r1_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (valid_q[$past(idx)] && (tag_q[$past(idx)] == $past(commit_tag))
                    && !dirty_q[$past(idx)]));
endmodule

// File: rtl/cache_data_store.sv
// Line data array, one word wide, addressed by {line, word}.
// One combinational read port and one write port; no reset on contents.
module cache_data_store #(
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int SEL_W = $clog2(WORDS),
    localparam int DEPTH = LINES * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_word
);
    logic [DATA_W-1:0] arr_q [DEPTH];

    // Word write from either a refill beat or a processor write.
    always_ff @(posedge clk) begin
        if (wr_en) arr_q[{wr_idx, wr_sel}] <= wr_word;
    end

    assign rd_word = arr_q[{rd_idx, rd_sel}];
endmodule

// File: rtl/cache_ctrl.sv
// Access and miss-sequence controller.
// Assumes the processor holds its request until cpu_ready, and memory
// accepts at most one beat per cycle through mem_ack.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int WORDS      = 4,
    parameter int WRITE_BACK = 1,
    localparam int SEL_W     = $clog2(WORDS),
    localparam logic [SEL_W-1:0] LAST = SEL_W'(WORDS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic             hit,
    input  logic             vic_dirty,
    input  logic             mem_ack,
    output cstate_e          state,
    output logic [SEL_W-1:0] beat,
    output logic             cpu_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_cancel,
    output logic             fill_wr,
    output logic             cpu_wr,
    output logic             set_dirty,
    output logic             commit
);
    cstate_e          state_q, state_d;
    logic [SEL_W-1:0] beat_q, beat_d;

    // State and beat counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // Next state, handshakes and array strobes.
    always_comb begin
        state_d    = state_q;
        beat_d     = beat_q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_cancel = 1'b0;
        fill_wr    = 1'b0;
        cpu_wr     = 1'b0;
        set_dirty  = 1'b0;
        commit     = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (cpu_req) begin
                    mem_req = 1'b1;
                    if (hit) begin
                        mem_cancel = 1'b1;
                        if (cpu_we) begin
                            cpu_wr = 1'b1;
                            if (WRITE_BACK != 0) begin
                                set_dirty = 1'b1;
                                cpu_ready = 1'b1;
                            end else begin
                                state_d = S_WTHRU;
                            end
                        end else begin
                            cpu_ready = 1'b1;
                        end
                    end else if (vic_dirty) begin
                        mem_cancel = 1'b1;
                        state_d    = S_EVICT;
                        beat_d     = '0;
                    end else begin
                        state_d = S_FILL;
                        if (mem_ack) begin
                            fill_wr = 1'b1;
                            beat_d  = SEL_W'(1);
                        end
                    end
                end
            end
            S_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    if (beat_q == LAST) begin
                        state_d = S_FILL;
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + SEL_W'(1);
                    end
                end
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_wr = 1'b1;
                    if (beat_q == LAST) begin
                        commit  = 1'b1;
                        state_d = S_IDLE;
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + SEL_W'(1);
                    end
                end
            end
            S_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign state = state_q;
    assign beat  = beat_q;

    a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    a_r3_stall_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVICT || state_q == S_FILL) |-> !cpu_ready);

    a_r10_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cancel |-> (state_q == S_IDLE && mem_req && !mem_we));

    a_r6_no_fill_over_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) == S_IDLE) |-> !$past(vic_dirty));

    a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_cancel && !mem_ack) |=> (mem_req && $stable(mem_we)));
endmodule

// File: rtl/dm_wb_cache.sv
// Top of the direct-mapped data cache: splits the address, looks up the
// indexed line and steers the arrays and memory port from the controller.
// Assumes word-aligned requests held until cpu_ready and WORDS >= 2.
module dm_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINES      = 64,
    parameter int WORDS      = 4,
    parameter int WRITE_BACK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_cancel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int SEL_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - SEL_W - OFF_W;

    logic [SEL_W-1:0]  cpu_sel;
    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic              line_valid, line_dirty, hit, vic_dirty;
    logic [TAG_W-1:0]  line_tag;
    cstate_e           state;
    logic [SEL_W-1:0]  beat;
    logic              fill_wr, cpu_wr, set_dirty, commit;
    logic [SEL_W-1:0]  rd_sel;
    logic [DATA_W-1:0] rd_word;

    assign cpu_sel = cpu_addr[OFF_W +: SEL_W];
    assign cpu_idx = cpu_addr[OFF_W + SEL_W +: IDX_W];
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    assign hit       = line_valid && (line_tag == cpu_tag);
    assign vic_dirty = line_valid && line_dirty && !hit;

    cache_tag_store #(
        .LINES(LINES), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(cpu_idx),
        .commit(commit), .commit_tag(cpu_tag), .set_dirty(set_dirty),
        .line_valid(line_valid), .line_tag(line_tag), .line_dirty(line_dirty)
    );

    // Eviction reads the victim word of the current beat; otherwise the
    // processor's word is read.
    assign rd_sel = (state == S_EVICT) ? beat : cpu_sel;

    cache_data_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)
    ) u_data (
        .clk(clk), .rd_idx(cpu_idx), .rd_sel(rd_sel), .rd_word(rd_word),
        .wr_en(fill_wr || cpu_wr), .wr_idx(cpu_idx),
        .wr_sel(fill_wr ? beat : cpu_sel),
        .wr_word(fill_wr ? mem_rdata : cpu_wdata)
    );

    cache_ctrl #(
        .WORDS(WORDS), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .hit(hit), .vic_dirty(vic_dirty), .mem_ack(mem_ack),
        .state(state), .beat(beat), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_cancel(mem_cancel),
        .fill_wr(fill_wr), .cpu_wr(cpu_wr), .set_dirty(set_dirty),
        .commit(commit)
    );

    // Memory beat address: victim block, refill block or forwarded word.
    always_comb begin
        case (state)
            S_EVICT: mem_addr = {line_tag, cpu_idx, beat, OFF_W'(0)};
            S_WTHRU: mem_addr = cpu_addr;
            default: mem_addr = {cpu_tag, cpu_idx, beat, OFF_W'(0)};
        endcase
    end

    assign mem_wdata = (state == S_WTHRU) ? cpu_wdata : rd_word;
    assign cpu_rdata = rd_word;

    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_cancel && !mem_ack) |=> $stable(mem_addr));

    a_r9_wt_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WTHRU) |-> (mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata));
endmodule

// File: tb/sim_dm_wb_cache.sv
`timescale 1ns/1ps

// Word memory with a varying per-beat latency; a beat counts only while
// requested and not cancelled.
module sim_mem_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        cancel,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic        ack,
    output logic [31:0] rdata
);
    logic [31:0] arr [1024];
    int          wr_beats;
    int          rd_beats;
    logic [1:0]  cnt;
    logic [1:0]  lat;
    logic [7:0]  lfsr;
    logic        active;

    function automatic logic [31:0] seed_word(int i);
        return (i * 32'h0001_0193) ^ 32'h5A5A_0000;
    endfunction

    assign active = req && !cancel;
    assign ack    = active && (cnt == lat);
    assign rdata  = arr[addr[11:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) arr[i] <= seed_word(i);
            wr_beats <= 0;
            rd_beats <= 0;
            cnt      <= 2'd0;
            lat      <= 2'd1;
            lfsr     <= 8'hA7;
        end else if (!active) begin
            cnt <= 2'd0;
        end else if (ack) begin
            cnt  <= 2'd0;
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            lat  <= lfsr[1:0];
            if (we) begin
                arr[addr[11:2]] <= wdata;
                wr_beats <= wr_beats + 1;
            end else begin
                rd_beats <= rd_beats + 1;
            end
        end else begin
            cnt <= cnt + 2'd1;
        end
    end
endmodule

module sim_dm_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, sel = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    int          checks = 0, failures = 0;

    logic [31:0] ref0 [1024];
    logic [31:0] ref1 [1024];

    logic        r0, r1, mq0, mq1, mc0, mc1, mw0, mw1, ak0, ak1;
    logic [31:0] rd0, rd1, ma0, ma1, md0, md1, mr0, mr1;

    always #2 clk = ~clk;

    dm_wb_cache #(.WRITE_BACK(1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(req && !sel), .cpu_we(we),
        .cpu_addr(addr), .cpu_wdata(wdata), .cpu_ready(r0), .cpu_rdata(rd0),
        .mem_req(mq0), .mem_cancel(mc0), .mem_we(mw0), .mem_addr(ma0),
        .mem_wdata(md0), .mem_ack(ak0), .mem_rdata(mr0));

    dm_wb_cache #(.WRITE_BACK(0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(req && sel), .cpu_we(we),
        .cpu_addr(addr), .cpu_wdata(wdata), .cpu_ready(r1), .cpu_rdata(rd1),
        .mem_req(mq1), .mem_cancel(mc1), .mem_we(mw1), .mem_addr(ma1),
        .mem_wdata(md1), .mem_ack(ak1), .mem_rdata(mr1));

    sim_mem_model m0 (.clk(clk), .rst_n(rst_n), .req(mq0), .cancel(mc0), .we(mw0),
        .addr(ma0), .wdata(md0), .ack(ak0), .rdata(mr0));
    sim_mem_model m1 (.clk(clk), .rst_n(rst_n), .req(mq1), .cancel(mc1), .we(mw1),
        .addr(ma1), .wdata(md1), .ack(ak1), .rdata(mr1));

    function automatic logic [31:0] init_word(int i);
        return (i * 32'h0001_0193) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One processor access on the selected instance.
    task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waits,
                          output bit sreq, output bit scan);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1;
        sreq  = sel ? mq1 : mq0;
        scan  = sel ? mc1 : mc0;
        waits = 0;
        while (!(sel ? r1 : r0) && waits < 500) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = sel ? rd1 : rd0;
        @(posedge clk); #1;
        req = 1'b0;
        if (w) begin
            if (sel) ref1[a[11:2]] = d; else ref0[a[11:2]] = d;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          waits, wb, rb, bad;
        bit          sreq, scan;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            ref0[i] = init_word(i);
            ref1[i] = init_word(i);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!r0 && !mq0 && !r1 && !mq1, "R1 idle after reset", {r0, mq0}, 0);

        // Write-back instance.
        sel = 1'b0;
        rb = m0.rd_beats;
        access(0, 32'h010, 0, rd, waits, sreq, scan);
        check(waits > 0, "R1 cold access misses", waits, 1);
        check(sreq && !scan, "R10 clean miss keeps request", {sreq, scan}, 2);
        check(rd == ref0[4], "R3 refill data", rd, ref0[4]);
        check(m0.rd_beats - rb == 4, "R12 four read beats", m0.rd_beats - rb, 4);
        access(0, 32'h01C, 0, rd, waits, sreq, scan);
        check(waits == 0, "R2 hit without wait", waits, 0);
        check(sreq && scan, "R10 hit cancels request", {sreq, scan}, 3);
        check(rd == ref0[7], "R4 word select", rd, ref0[7]);
        wb = m0.wr_beats;
        access(1, 32'h014, 32'hCAFE_0001, rd, waits, sreq, scan);
        check(waits == 0, "R5 write hit no wait", waits, 0);
        access(1, 32'h018, 32'hCAFE_0002, rd, waits, sreq, scan);
        access(1, 32'h014, 32'hCAFE_0003, rd, waits, sreq, scan);
        check(m0.wr_beats == wb, "R5 no memory write", m0.wr_beats - wb, 0);
        wb = m0.wr_beats;
        access(0, 32'h410, 0, rd, waits, sreq, scan);
        check(sreq && scan, "R10 dirty victim cancels", {sreq, scan}, 3);
        check(m0.wr_beats - wb == 4, "R6 four write-back beats", m0.wr_beats - wb, 4);
        check(m0.arr[5] == 32'hCAFE_0003, "R6 victim word in memory", m0.arr[5], 32'hCAFE_0003);
        check(m0.arr[6] == 32'hCAFE_0002, "R6 victim word in memory", m0.arr[6], 32'hCAFE_0002);
        check(rd == ref0[260], "R11 conflicting tag refills", rd, ref0[260]);
        wb = m0.wr_beats;
        access(0, 32'h014, 0, rd, waits, sreq, scan);
        check(waits > 0, "R11 evicted address misses", waits, 1);
        check(rd == 32'hCAFE_0003, "R3 data after re-refill", rd, 32'hCAFE_0003);
        check(m0.wr_beats == wb, "R7 clean victim no write", m0.wr_beats - wb, 0);
        access(1, 32'h824, 32'hBEEF_0009, rd, waits, sreq, scan);
        check(waits > 0, "R8 write miss stalls", waits, 1);
        access(0, 32'h820, 0, rd, waits, sreq, scan);
        check(waits == 0 && rd == ref0[520], "R8 allocated neighbour", rd, ref0[520]);
        access(0, 32'h824, 0, rd, waits, sreq, scan);
        check(rd == 32'hBEEF_0009, "R8 merged word", rd, 32'hBEEF_0009);

        // Write-through instance.
        sel = 1'b1;
        wb = m1.wr_beats;
        access(1, 32'h030, 32'h1234_5678, rd, waits, sreq, scan);
        check(m1.wr_beats - wb == 1 && m1.arr[12] == 32'h1234_5678,
              "R9 write miss forwarded", m1.arr[12], 32'h1234_5678);
        wb = m1.wr_beats;
        access(1, 32'h034, 32'h0BAD_F00D, rd, waits, sreq, scan);
        check(waits > 0, "R9 write hit stalls", waits, 1);
        check(m1.wr_beats - wb == 1, "R9 one write beat", m1.wr_beats - wb, 1);
        access(0, 32'h034, 0, rd, waits, sreq, scan);
        check(waits == 0 && rd == 32'h0BAD_F00D, "R2 read after write", rd, 32'h0BAD_F00D);
        wb = m1.wr_beats;
        access(0, 32'h430, 0, rd, waits, sreq, scan);
        check(m1.wr_beats == wb, "R9 no write-back", m1.wr_beats - wb, 0);

        // Random mix on both instances.
        for (int n = 0; n < 800; n++) begin
            logic [31:0] a, d, e;
            bit          w;
            sel = 1'($urandom % 2);
            a   = ($urandom % 1024) << 2;
            d   = $urandom;
            w   = ($urandom % 10) < 4;
            access(w, a, d, rd, waits, sreq, scan);
            if (!w) begin
                e = sel ? ref1[a[11:2]] : ref0[a[11:2]];
                check(rd == e, "R4 random read", rd, e);
            end
        end

        bad = 0;
        for (int i = 0; i < 1024; i++) if (m1.arr[i] !== ref1[i]) bad++;
        check(bad == 0, "R9 memory matches writes", bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule